// File: doc/BRIEF.md
# Cascadable Bidirectional Parity Unit

This block computes parity over a 9-bit data word and either drives the result onto a shared, single-wire parity line or compares that line against its own result. A mode input selects the role. In transmit mode the block drives the line and holds its active-low error flag inactive. In check mode it releases the line, reads the parity sent by another agent, and pulls the error flag low when the received bit disagrees with the locally generated one.

Several units can be chained to cover words wider than nine bits. Each lower unit runs in transmit mode, and its generated bit enters bit 0 of the next unit's word. Only the last unit sees the external mode input and owns the bus line. A chain of `NUM_UNITS` units therefore takes `8*NUM_UNITS+1` external data bits. Inside the core the line is split into in, out and output-enable signals, and the top resolves them onto an inout pin. The logic is purely combinational.

Top module: `parity_chain_top`

## Requirements
- R1: With `check_mode_i` low, `parity_oe_o` is 1 and the block drives `parity_io`. With `check_mode_i` high, `parity_oe_o` is 0 and the block leaves `parity_io` free, so an external driver sets the line.
- R2: For a single unit (`NUM_UNITS`=1) in transmit mode, `parity_io` is 1 when the number of ones in the 9 data bits is even (0, 2, 4, 6, 8) and 0 when that number is odd.
- R3: In transmit mode `err_no` is 1 for every data value.
- R4: In check mode, `err_no` is 0 exactly when the level on `parity_io` differs from the value the block would drive in transmit mode for the same data. It is 1 otherwise.
- R5: For a single unit in check mode, `err_no` is 0 for an even count of ones with the line at 0, and for an odd count with the line at 1.
- R6: In a chain, the lower units always run in transmit mode, and each lower unit's generated bit is bit 0 of the next unit's 9-bit word. Unit 0 takes `data_i[8:0]`, and unit k>0 takes `data_i[9+8(k-1) +: 8]` as its bits 8..1.
- R7: For a chain of `NUM_UNITS` units in transmit mode, `parity_io` is 1 exactly when (number of ones in `data_i`) + `NUM_UNITS` - 1 is even. The polarity therefore alternates with chain length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8*NUM_UNITS+1 | External data bits across the whole chain |
| check_mode_i | input | 1 | 0 = transmit (drive parity), 1 = check (receive parity) |
| parity_io | inout | 1 | Shared parity line |
| parity_oe_o | output | 1 | 1 while the block drives `parity_io` |
| err_no | output | 1 | Active-low parity mismatch flag |

## Verification
The assertions check several things on every evaluation: the error flag stays high in transmit mode; in check mode the flag agrees with a comparison between the line and the generated bit; every lower chain unit stays in transmit mode with its flag high; and the resolved line matches the driven value while the output is enabled. Only the bench scenarios show the absolute parity polarity: even-count-drives-high for one unit, and the alternating polarity for a two-unit chain. The same holds for the bit placement of the chained word, since those come from a popcount model over all 512 low-word patterns in both modes and at both line levels.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  assign odd_o = ^data_i;
endmodule

// File: rtl/parity_unit.sv
module parity_unit
  import parity_pkg::*;
(
  input  word_t data_i,
  input  logic  check_mode_i,
  input  logic  parity_i,
  output logic  parity_o,
  output logic  parity_oe_o,
  output logic  err_no
);
  logic odd_w;

  parity_tree #(.W(WORD_W)) u_tree (
    .data_i (data_i),
    .odd_o  (odd_w)
  );

  assign parity_o    = ~odd_w;
  assign parity_oe_o = ~check_mode_i;
  assign err_no      = ~(check_mode_i & (parity_i ^ parity_o));

  always_comb begin
    if (!$isunknown(check_mode_i) && !check_mode_i)
      AST_TX_FLAG_IDLE: assert (err_no == 1'b1); // R3
  end

  always_comb begin
    if (!$isunknown({check_mode_i, parity_i, data_i}) && check_mode_i)
      AST_RX_FLAG_MATCH: assert (err_no == (parity_i == parity_o)); // R4
  end
endmodule

// File: rtl/parity_cascade.sv
module parity_cascade
  import parity_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 2
) (
  input  logic [(WORD_W-1)*NUM_UNITS:0] data_i,
  input  logic                          check_mode_i,
  input  logic                          parity_i,
  output logic                          parity_o,
  output logic                          parity_oe_o,
  output logic                          err_no
);
  localparam int unsigned LAST = NUM_UNITS - 1;
  localparam int unsigned SEG  = WORD_W - 1;

  logic [NUM_UNITS-1:0] par_w, oe_w, errn_w;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    word_t word_w;
    logic  mode_w, pin_w;
    if (k == 0) begin : g_first
      assign word_w = data_i[WORD_W-1:0];
    end else begin : g_chain
      assign word_w = {data_i[WORD_W + (k-1)*SEG +: SEG], par_w[k-1]};
    end
    if (k == LAST) begin : g_head
      assign mode_w = check_mode_i;
      assign pin_w  = parity_i;
    end else begin : g_lower
      assign mode_w = 1'b0;
      assign pin_w  = 1'b0;
    end
    parity_unit u_unit (
      .data_i       (word_w),
      .check_mode_i (mode_w),
      .parity_i     (pin_w),
      .parity_o     (par_w[k]),
      .parity_oe_o  (oe_w[k]),
      .err_no       (errn_w[k])
    );
  end

  assign parity_o    = par_w[LAST];
  assign parity_oe_o = oe_w[LAST];
  assign err_no      = errn_w[LAST];

  // lower units must stay in transmit with quiet flags
  always_comb begin
    for (int k = 0; k < int'(LAST); k++) begin
      if (!$isunknown(data_i))
        AST_LOWER_TX: assert (oe_w[k] && errn_w[k]); // R6
    end
  end
endmodule

// File: rtl/parity_chain_top.sv
module parity_chain_top
  import parity_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 2
) (
  input  logic [(WORD_W-1)*NUM_UNITS:0] data_i,
  input  logic                          check_mode_i,
  inout  wire                           parity_io,
  output logic                          parity_oe_o,
  output logic                          err_no
);
  logic par_out_w, par_in_w;

  parity_cascade #(.NUM_UNITS(NUM_UNITS)) u_core (
    .data_i       (data_i),
    .check_mode_i (check_mode_i),
    .parity_i     (par_in_w),
    .parity_o     (par_out_w),
    .parity_oe_o  (parity_oe_o),
    .err_no       (err_no)
  );

  assign parity_io = parity_oe_o ? par_out_w : 1'bz;
  assign par_in_w  = parity_io;

  always_comb begin
    if (!$isunknown({parity_oe_o, par_out_w}) && parity_oe_o)
      AST_LINE_DRIVEN: assert (par_in_w == par_out_w); // R1
  end
endmodule

// File: tb/parity_chain_top_tb_top.sv
module parity_chain_top_tb_top;
  localparam int unsigned N2 = 2;
  localparam int unsigned W2 = 8*N2 + 1;
  localparam int unsigned W1 = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [W2-1:0] d2;
  logic [W1-1:0] d1;
  logic mode;
  logic drv_en, drv_val;
  wire  line2, line1;
  logic oe2, oe1, errn2, errn1;

  assign line2 = drv_en ? drv_val : 1'bz;
  assign line1 = drv_en ? drv_val : 1'bz;

  parity_chain_top #(.NUM_UNITS(N2)) dut_i (
    .data_i(d2), .check_mode_i(mode), .parity_io(line2),
    .parity_oe_o(oe2), .err_no(errn2));

  parity_chain_top #(.NUM_UNITS(1)) dut_one_i (
    .data_i(d1), .check_mode_i(mode), .parity_io(line1),
    .parity_oe_o(oe1), .err_no(errn1));

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b d2=%h d1=%h mode=%b line=%b",
               req, act, exp, d2, d1, mode, drv_val);
    end
  endtask

  function automatic int ones(input logic [W2-1:0] v);
    int c = 0;
    for (int i = 0; i < int'(W2); i++) c += int'(v[i]);
    return c;
  endfunction

  // reference: line level for a chain of n units
  function automatic logic ref_par(input int cnt, input int n);
    return ((cnt + n - 1) % 2) == 0;
  endfunction

  task automatic apply(input logic [W2-1:0] v2, input logic [W1-1:0] v1,
                       input logic m, input logic en, input logic lv);
    @(negedge clk);
    d2 = v2; d1 = v1; mode = m; drv_en = en; drv_val = lv;
    @(posedge clk);
    #1;
  endtask

  task automatic check_vec(input logic [W2-1:0] v2, input logic [W1-1:0] v1,
                           input logic m, input logic lv);
    logic e2, e1;
    e2 = ref_par(ones(v2), N2);
    e1 = ref_par(ones({{(W2-W1){1'b0}}, v1}), 1);
    apply(v2, v1, m, m, lv);
    if (!m) begin
      chk("R1 oe tx chain", oe2, 1'b1);
      chk("R1 oe tx single", oe1, 1'b1);
      chk("R2 single parity", line1, e1);
      chk("R7 chain parity", line2, e2);
      chk("R3 flag tx chain", errn2, 1'b1);
      chk("R3 flag tx single", errn1, 1'b1);
    end else begin
      chk("R1 oe rx chain", oe2, 1'b0);
      chk("R1 oe rx single", oe1, 1'b0);
      chk("R1 line follows external", line2, lv);
      chk("R5 single flag", errn1, (lv == e1));
      chk("R4 chain flag", errn2, (lv == e2));
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    d2 = '0; d1 = '0; mode = 1'b0; drv_en = 1'b0; drv_val = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // idle state: all zero data, transmit
    chk("R2 idle single high", line1, 1'b1);
    chk("R7 idle chain low", line2, 1'b0);
    chk("R3 idle flag", errn2, 1'b1);

    // R5 corner cases from the rule
    check_vec('0, 9'h000, 1'b1, 1'b0);
    chk("R5 even-low flags", errn1, 1'b0);
    check_vec('0, 9'h001, 1'b1, 1'b1);
    chk("R5 odd-high flags", errn1, 1'b0);
    check_vec('0, 9'h1FF, 1'b1, 1'b0);
    chk("R5 nine-ones low ok", errn1, 1'b1);

    // R6: upper segment alone toggles the chained result
    check_vec({8'h01, 9'h000}, 9'h000, 1'b0, 1'b0);
    chk("R6 upper bit reaches head", line2, 1'b1);
    check_vec({8'h00, 9'h001}, 9'h000, 1'b0, 1'b0);
    chk("R6 low bit reaches head via chain", line2, 1'b1);
    check_vec({W2{1'b1}}, 9'h1FF, 1'b0, 1'b0);

    for (int i = 0; i < 512; i++) begin
      logic [7:0] hi;
      hi = 8'((i * 37 + 11) & 8'hFF);
      check_vec({hi, 9'(i)}, 9'(i), 1'b0, 1'b0);
      check_vec({hi, 9'(i)}, 9'(i), 1'b1, 1'b0);
      check_vec({hi, 9'(i)}, 9'(i), 1'b1, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule